// File: doc/BRIEF.md
# Big-Endian Load/Store Lane Aligner

This block sits on the data side of a 32-bit core, between the address adder and a byte-addressed memory that is organized as 32-bit words. On a load it takes the word returned by memory and selects the byte, halfword or full word named by the low address bits and the access size. It then widens the item to 32 bits, filling the upper bits with copies of the item's top bit or with zeros, as the signed flag requests.

On a store it places the low byte or low halfword of the source register on every matching lane of the write bus. It also produces a 4-bit per-lane write enable, so the enables alone pick the bytes that memory updates. Lane numbering is big endian: the lowest address in a word maps to the most significant byte. A request whose address does not suit its size raises a misalignment flag and writes nothing.

All results are registered once. A request presented with `req_vld` high appears on the outputs after the next rising clock edge, and the outputs hold their values while no request arrives.

Top module: `be_lsu_align`

## Requirements
- R1: While `rst_n` is low, and until two clock edges after it is released, `rsp_vld`, `misalign`, `ld_data`, `st_wdata` and `st_be` are all zero.
- R2: A word access (`req_size` 2'b10, and 2'b11, which is treated as a word) whose address bits 1:0 are not 2'b00 sets `misalign`. Such an access is accepted as aligned when those bits are 2'b00.
- R3: A halfword access (`req_size` 2'b01) sets `misalign` exactly when address bit 0 is 1. A byte access (`req_size` 2'b00) never sets it.
- R4: Lane selection is big endian. Byte offset k (address bits 1:0) reads `mem_rdata` bits 31-8k down to 24-8k. A halfword at offset 0 reads bits 31:16 and one at offset 2 reads bits 15:0. A word load returns `mem_rdata` unchanged.
- R5: An aligned signed load (`req_signed`=1) of a byte or halfword copies the item's top bit into every upper bit of `ld_data`.
- R6: An aligned unsigned load (`req_signed`=0) of a byte or halfword fills the upper bits of `ld_data` with zeros.
- R7: `st_be` bit i enables bits 8i+7:8i. A byte store at offset k sets only bit 3-k. A halfword store sets 4'b1100 at offset 0 and 4'b0011 at offset 2. A word store sets 4'b1111. `st_be` is 4'b0000 for loads and for any misaligned access.
- R8: On a store, `st_wdata` carries `st_src[7:0]` in all four lanes for a byte, `st_src[15:0]` in both halves for a halfword, and `st_src` unchanged for a word, whether or not the access is misaligned. On a load it is zero.
- R9: `ld_data` is zero for stores and for misaligned loads.
- R10: Results appear on the outputs one clock after the request, with `rsp_vld` high for that one cycle. In cycles after `req_vld` was low, `rsp_vld` is low and the other outputs keep their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_vld | input | 1 | Request present this cycle |
| req_store | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | 00 byte, 01 halfword, 10/11 word |
| req_signed | input | 1 | Sign-extend byte/halfword loads |
| req_addr | input | ADDR_W (32) | Effective byte address |
| st_src | input | 32 | Store source register value |
| mem_rdata | input | 32 | Word read from memory for a load |
| rsp_vld | output | 1 | Registered results valid |
| ld_data | output | 32 | Extended load result |
| st_wdata | output | 32 | Lane-replicated store data |
| st_be | output | 4 | Per-lane write enables |
| misalign | output | 1 | Address does not suit access size |

## Verification
Misalignment detection and store-enable generation act together on one store. Every store of a halfword or word to an odd or unaligned offset must still carry the replicated write data and raise `misalign`, while all enables stay low. The stimulus sweeps every size, offset and signed setting for both loads and stores, back to back and with idle gaps. A behavioural model in the bench computes each lane with integer shifts, and it is compared with every output on every clock. The zero enables and the intact write data of a misaligned store are therefore judged in the same response cycle.

// File: rtl/be_lsu_pkg.sv
package be_lsu_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned LANE_W = 8;
  localparam int unsigned LANES  = WORD_W / LANE_W;
  localparam int unsigned OFS_W  = $clog2(LANES);

  typedef enum logic [1:0] {
    ACC_BYTE = 2'b00,
    ACC_HALF = 2'b01,
    ACC_WORD = 2'b10,
    ACC_WIDE = 2'b11
  } acc_size_e;

  typedef struct packed {
    logic [WORD_W-1:0] ld;
    logic [WORD_W-1:0] wd;
    logic [LANES-1:0]  be;
    logic              mis;
  } lsu_rsp_t;
endpackage

// File: rtl/be_lsu_misalign.sv
module be_lsu_misalign
  import be_lsu_pkg::*;
(
  input  logic [1:0]       size_i,
  input  logic [OFS_W-1:0] ofs_i,
  output logic             mis_o
);
  always_comb begin
    case (acc_size_e'(size_i))
      ACC_BYTE: mis_o = 1'b0;
      ACC_HALF: mis_o = ofs_i[0];
      default:  mis_o = |ofs_i;
    endcase
  end
endmodule

// File: rtl/be_lsu_ldext.sv
module be_lsu_ldext
  import be_lsu_pkg::*;
(
  input  logic [1:0]        size_i,
  input  logic              sgn_i,
  input  logic [OFS_W-1:0]  ofs_i,
  input  logic [WORD_W-1:0] rdata_i,
  output logic [WORD_W-1:0] ld_o
);
  logic [LANE_W-1:0]   lane [LANES];
  logic [LANE_W-1:0]   byte_sel;
  logic [2*LANE_W-1:0] half_sel;
  logic [OFS_W-1:0]    hi_idx;
  logic [OFS_W-1:0]    lo_idx;

  // lane k holds the byte at address offset k (big endian)
  for (genvar k = 0; k < LANES; k++) begin : g_lane
    assign lane[k] = rdata_i[WORD_W-1-LANE_W*k -: LANE_W];
  end

  always_comb begin
    hi_idx   = {ofs_i[OFS_W-1:1], 1'b0};
    lo_idx   = {ofs_i[OFS_W-1:1], 1'b1};
    byte_sel = lane[ofs_i];
    half_sel = {lane[hi_idx], lane[lo_idx]};
  end

  always_comb begin
    case (acc_size_e'(size_i))
      ACC_BYTE: ld_o = {{(WORD_W-LANE_W){sgn_i & byte_sel[LANE_W-1]}}, byte_sel};
      ACC_HALF: ld_o = {{(WORD_W-2*LANE_W){sgn_i & half_sel[2*LANE_W-1]}}, half_sel};
      default:  ld_o = rdata_i;
    endcase
  end
endmodule

// File: rtl/be_lsu_stpack.sv
module be_lsu_stpack
  import be_lsu_pkg::*;
(
  input  logic [1:0]        size_i,
  input  logic [OFS_W-1:0]  ofs_i,
  input  logic [WORD_W-1:0] src_i,
  output logic [WORD_W-1:0] wd_o,
  output logic [LANES-1:0]  be_o
);
  always_comb begin
    case (acc_size_e'(size_i))
      ACC_BYTE: wd_o = {LANES{src_i[LANE_W-1:0]}};
      ACC_HALF: wd_o = {(LANES/2){src_i[2*LANE_W-1:0]}};
      default:  wd_o = src_i;
    endcase
  end

  // enable bit i guards bits 8i+7:8i, i.e. address offset LANES-1-i
  for (genvar i = 0; i < LANES; i++) begin : g_be
    localparam logic [OFS_W-1:0] LANE_OFS = OFS_W'(LANES - 1 - i);
    always_comb begin
      case (acc_size_e'(size_i))
        ACC_BYTE: be_o[i] = (ofs_i == LANE_OFS);
        ACC_HALF: be_o[i] = (ofs_i[OFS_W-1:1] == LANE_OFS[OFS_W-1:1]);
        default:  be_o[i] = 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/be_lsu_align.sv
module be_lsu_align
  import be_lsu_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_vld,
  input  logic              req_store,
  input  logic [1:0]        req_size,
  input  logic              req_signed,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [31:0]       st_src,
  input  logic [31:0]       mem_rdata,
  output logic              rsp_vld,
  output logic [31:0]       ld_data,
  output logic [31:0]       st_wdata,
  output logic [3:0]        st_be,
  output logic              misalign
);
  logic             rst_s0;
  logic             rst_q;
  logic [OFS_W-1:0] ofs;
  logic             mis_c;
  logic [WORD_W-1:0] ld_raw;
  logic [WORD_W-1:0] wd_raw;
  logic [LANES-1:0]  be_raw;
  lsu_rsp_t          rsp_d;
  lsu_rsp_t          rsp_q;
  logic              vld_q;

  // reset: asserted asynchronously, released after two edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s0 <= 1'b0;
      rst_q  <= 1'b0;
    end else begin
      rst_s0 <= 1'b1;
      rst_q  <= rst_s0;
    end
  end

  assign ofs = req_addr[OFS_W-1:0];

  be_lsu_misalign u_mis (
    .size_i (req_size),
    .ofs_i  (ofs),
    .mis_o  (mis_c)
  );

  be_lsu_ldext u_ld (
    .size_i  (req_size),
    .sgn_i   (req_signed),
    .ofs_i   (ofs),
    .rdata_i (mem_rdata),
    .ld_o    (ld_raw)
  );

  be_lsu_stpack u_st (
    .size_i (req_size),
    .ofs_i  (ofs),
    .src_i  (st_src),
    .wd_o   (wd_raw),
    .be_o   (be_raw)
  );

  // next-state
  always_comb begin
    rsp_d.mis = mis_c;
    rsp_d.ld  = (!req_store && !mis_c) ? ld_raw : '0;
    rsp_d.wd  = req_store ? wd_raw : '0;
    rsp_d.be  = (req_store && !mis_c) ? be_raw : '0;
  end

  // registers
  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      vld_q <= 1'b0;
      rsp_q <= '0;
    end else begin
      vld_q <= req_vld;
      if (req_vld) begin
        rsp_q <= rsp_d;
      end
    end
  end

  assign rsp_vld  = vld_q;
  assign ld_data  = rsp_q.ld;
  assign st_wdata = rsp_q.wd;
  assign st_be    = rsp_q.be;
  assign misalign = rsp_q.mis;

  // R7
  mis_no_be_chk: assert property (@(posedge clk) disable iff (!rst_q)
    misalign |-> (st_be == 4'b0000));

  // R7
  byte_one_lane_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (req_vld && req_store && req_size == 2'b00) |=> ($countones(st_be) == 1));

  // R3
  byte_never_mis_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (req_vld && req_size == 2'b00) |=> !misalign);

  // R5
  sbyte_ext_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (req_vld && !req_store && req_signed && req_size == 2'b00)
      |=> (ld_data[31:8] == {24{ld_data[7]}}));

  // R6
  uhalf_zero_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (req_vld && !req_store && !req_signed && req_size == 2'b01)
      |=> (ld_data[31:16] == 16'h0000));

  // R9
  store_no_ld_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (req_vld && req_store) |=> (ld_data == 32'h0));

  // R10
  rsp_follow_chk: assert property (@(posedge clk) disable iff (!rst_q)
    req_vld |=> rsp_vld);

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_q)
    !req_vld |=> (!rsp_vld && $stable(ld_data) && $stable(st_wdata)
                  && $stable(st_be) && $stable(misalign)));
endmodule

// File: tb/be_lsu_align_bench.sv
module be_lsu_align_bench;
  logic        clk;
  logic        rst_n;
  logic        req_vld;
  logic        req_store;
  logic [1:0]  req_size;
  logic        req_signed;
  logic [31:0] req_addr;
  logic [31:0] st_src;
  logic [31:0] mem_rdata;
  logic        rsp_vld;
  logic [31:0] ld_data;
  logic [31:0] st_wdata;
  logic [3:0]  st_be;
  logic        misalign;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit done   = 0;

  // expected state
  logic        e_vld = 0;
  logic [31:0] e_ld = 0, e_wd = 0;
  logic [3:0]  e_be = 0;
  logic        e_mis = 0;
  string       t_ld = "R10", t_wd = "R10", t_be = "R10", t_mis = "R10";

  be_lsu_align u_be_lsu_align (
    .clk(clk), .rst_n(rst_n), .req_vld(req_vld), .req_store(req_store),
    .req_size(req_size), .req_signed(req_signed), .req_addr(req_addr),
    .st_src(st_src), .mem_rdata(mem_rdata), .rsp_vld(rsp_vld),
    .ld_data(ld_data), .st_wdata(st_wdata), .st_be(st_be), .misalign(misalign)
  );

  initial clk = 0;
  always #4 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  // behavioural reference model
  always @(posedge clk) begin
    cycles++;
    if (!rst_n) begin
      e_vld = 0; e_ld = 0; e_wd = 0; e_be = 0; e_mis = 0;
    end else begin
      e_vld = req_vld;
      if (req_vld) begin
        int off;
        int bv, hv;
        off = int'(req_addr & 32'd3);
        bv  = int'((mem_rdata >> (8 * (3 - off))) & 32'hFF);
        hv  = int'((mem_rdata >> ((off >= 2) ? 0 : 16)) & 32'hFFFF);
        if (req_size == 2'd0)      e_mis = 0;
        else if (req_size == 2'd1) e_mis = (off % 2) != 0;
        else                       e_mis = off != 0;
        t_mis = (req_size == 2'd1 || req_size == 2'd0) ? "R3" : "R2";
        if (req_store || e_mis) begin
          e_ld = 0; t_ld = "R9";
        end else if (req_size == 2'd0) begin
          e_ld = 32'(bv);
          if (req_signed && bv >= 128) e_ld = e_ld | 32'hFFFF_FF00;
          t_ld = req_signed ? "R5" : "R6";
        end else if (req_size == 2'd1) begin
          e_ld = 32'(hv);
          if (req_signed && hv >= 32768) e_ld = e_ld | 32'hFFFF_0000;
          t_ld = req_signed ? "R5" : "R6";
        end else begin
          e_ld = mem_rdata; t_ld = "R4";
        end
        if (req_store && !e_mis) begin
          if (req_size == 2'd0)      e_be = 4'(1 << (3 - off));
          else if (req_size == 2'd1) e_be = (off < 2) ? 4'hC : 4'h3;
          else                       e_be = 4'hF;
        end else e_be = 0;
        t_be = "R7";
        if (!req_store)            e_wd = 0;
        else if (req_size == 2'd0) e_wd = 32'(st_src[7:0]) * 32'h0101_0101;
        else if (req_size == 2'd1) e_wd = 32'(st_src[15:0]) * 32'h0001_0001;
        else                       e_wd = st_src;
        t_wd = "R8";
      end else begin
        t_ld = "R10"; t_wd = "R10"; t_be = "R10"; t_mis = "R10";
      end
    end
  end

  // compare away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R10", 32'(rsp_vld), 32'(e_vld));
      chk(t_ld,  ld_data, e_ld);
      chk(t_wd,  st_wdata, e_wd);
      chk(t_be,  32'(st_be), 32'(e_be));
      chk(t_mis, 32'(misalign), 32'(e_mis));
    end
  end

  // watchdog
  initial begin
    #(8 * 100000);
    fails++;
    $display("FAIL watchdog expired act=running exp=finished");
    finish_run();
  end

  task automatic drive(input logic st, input logic [1:0] sz, input logic sg,
                       input logic [31:0] a, input logic [31:0] src, input logic [31:0] rd);
    @(negedge clk);
    req_vld = 1; req_store = st; req_size = sz; req_signed = sg;
    req_addr = a; st_src = src; mem_rdata = rd;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      req_vld = 0; req_addr = $urandom; st_src = $urandom; mem_rdata = $urandom;
      req_size = 2'($urandom); req_store = 1'($urandom);
    end
  endtask

  initial begin
    rst_n = 0; req_vld = 0; req_store = 0; req_size = 0; req_signed = 0;
    req_addr = 0; st_src = 0; mem_rdata = 0;
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    chk("R1", 32'(rsp_vld), 0);
    chk("R1", ld_data, 0);
    chk("R1", st_wdata, 0);
    chk("R1", 32'(st_be), 0);
    chk("R1", 32'(misalign), 0);
    @(negedge clk);
    rst_n = 1;
    idle(4);
    // R4 R5 R6 R7 R8 R2 R3: full sweep on fixed patterns
    for (int p = 0; p < 3; p++) begin
      logic [31:0] rd;
      rd = (p == 0) ? 32'h8172_E3F4 : (p == 1) ? 32'h7F00_80FF : 32'h0180_7FFE;
      for (int st = 0; st < 2; st++)
        for (int sz = 0; sz < 4; sz++)
          for (int sg = 0; sg < 2; sg++)
            for (int of = 0; of < 4; of++)
              drive(1'(st), 2'(sz), 1'(sg), 32'h0000_1000 + 32'(of),
                    32'hA5C3_96E1 ^ 32'(p * 32'h1111_1111), rd);
      idle(3);
    end
    // R10: interleaved idle cycles between requests
    for (int i = 0; i < 200; i++) begin
      drive(1'($urandom), 2'($urandom), 1'($urandom), $urandom, $urandom, $urandom);
      if ($urandom % 3 == 0) idle(1 + int'($urandom % 3));
    end
    idle(3);
    done = 1;
    finish_run();
  end
endmodule